// File: doc/BRIEF.md
# DMA Engine Status and Interrupt Register

This block is the 32-bit status word of a bus-master DMA engine. It keeps sticky records of completions and errors that the engine reports as one-cycle pulses. Software reads the record, then clears it bit by bit by writing ones to the positions it has handled. The same word also shows live information that this block does not store. That information is the FIFO occupancy and pointers, whether the engine is using the bus, and two bits copied from the engine's configuration register.

Two interrupt requests are formed from the stored flags and from enable bits held in the configuration register. The done request covers the two normal completions. The error request covers the five error flags, and each error flag has its own enable. Both requests appear as bits of the status word and as level outputs for an interrupt controller. A summary bit for an abnormal chain end is the OR of the five error flags, so it clears only once all five have been cleared.

Top module: `dma_stat_reg`

## Requirements
- R1: After a synchronous active-low reset, all stored flags are 0. With all live inputs at 0, `rd_data` reads 0 and both `irq_done` and `irq_err` are 0.
- R2: An event pulse sampled at a clock edge sets its flag, and the flag shows in `rd_data` after that edge. The mapping is: chain-complete to bit 8, transfer-complete to bit 7, and `ev_err[i]` to bit i. The error bits are 0 data, 1 chain, 2 bus, 3 system and 4 parity.
- R3: When `wr_en` is high, each flag (bits 8, 7 and 4:0) whose position in `wr_data` is 1 clears at that edge. A 0 in `wr_data` leaves the flag unchanged.
- R4: If a set pulse and a write-one-to-clear reach the same flag in the same cycle, the flag ends up at 1.
- R5: Bit 9 always equals the OR of bits 4:0. Writing to bit 9 has no effect on it.
- R6: Bit 12 and `irq_done` are 1 when either of two pairs is fully set: bit 8 with `ie_chain_done`, or bit 7 with `ie_xfer_done`. Otherwise they are 0.
- R7: Bit 13 and `irq_err` are 1 exactly when some error flag i is set and `ie_err[i]` is 1.
- R8: Bit 11 mirrors `cfg_chain_en` and bit 10 mirrors `cfg_xfer_act` in the same cycle.
- R9: Bit 14 mirrors `bus_busy` in the same cycle.
- R10: The FIFO fields mirror their inputs in the same cycle: `fifo_cnt` in bits 28:24, `fifo_wp` in bits 23:20 and `fifo_rp` in bits 19:16.
- R11: Bits 31:29, 15 and 6:5 read 0, and writing 1 to them changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write data; a 1 clears the matching flag |
| rd_data | output | 32 | Current status word |
| ev_chain_done | input | 1 | One-cycle pulse: chain finished normally |
| ev_xfer_done | input | 1 | One-cycle pulse: transfer finished normally |
| ev_err | input | 5 | One-cycle error pulses, one bit per error flag |
| fifo_cnt | input | 5 | FIFO valid-entry count |
| fifo_wp | input | 4 | FIFO write pointer |
| fifo_rp | input | 4 | FIFO read pointer |
| bus_busy | input | 1 | Engine is requesting or using the bus |
| cfg_chain_en | input | 1 | Chain-enable bit of the configuration register |
| cfg_xfer_act | input | 1 | Transfer-active bit of the configuration register |
| ie_chain_done | input | 1 | Enable for the chain-complete interrupt |
| ie_xfer_done | input | 1 | Enable for the transfer-complete interrupt |
| ie_err | input | 5 | Per-flag enables for the error interrupt |
| irq_done | output | 1 | Done interrupt request, level |
| irq_err | output | 1 | Error interrupt request, level |

## Verification
Each stored flag is a single register, so a wrong flag is visible in `rd_data` in the first cycle after the edge that corrupted it. With its enable held high, it also reaches `irq_done` or `irq_err` in that same cycle. A clear that hits the wrong bit shows up in the next read as a neighbouring flag dropping, or as a flag that stays set. A lost set under a simultaneous clear shows up as a zero right after the colliding edge. Mirror and reserved fields have no storage, so a wrong mapping is visible in the same cycle the inputs change.

// File: rtl/dma_stat_pkg.sv
// Package: field positions and widths of the DMA status word.
// Assumes a 32-bit word; positions are fixed because software decodes them.
package dma_stat_pkg;
    localparam int WORD_W      = 32;
    localparam int NUM_ERR     = 5;
    localparam int CNT_W       = 5;
    localparam int PTR_W       = 4;

    localparam int POS_ERR_LSB = 0;
    localparam int POS_XFER    = 7;
    localparam int POS_CHAIN   = 8;
    localparam int POS_ABN     = 9;
    localparam int POS_XACT    = 10;
    localparam int POS_CHEN    = 11;
    localparam int POS_IDONE   = 12;
    localparam int POS_IERR    = 13;
    localparam int POS_BUSY    = 14;
    localparam int POS_RP_LSB  = 16;
    localparam int POS_WP_LSB  = POS_RP_LSB + PTR_W;
    localparam int POS_CNT_LSB = POS_WP_LSB + PTR_W;

    // Snapshot of the live (non-stored) fields
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic             busy;
        logic             chain_en;
        logic             xfer_act;
    } live_t;
endpackage

// File: rtl/dma_stat_flag_bank.sv
// Module: bank of N sticky flags with write-one-to-clear.
// Each flag is set by a one-cycle pulse and cleared by a 1 on its clear line.
// A set and a clear in the same cycle leave the flag set.
// Assumes: the clear lines are already qualified by the write strobe.
module dma_stat_flag_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic q_r;

        // Hold one flag: set dominates, then clear, else keep
        always_ff @(posedge clk) begin
            if (!rst_n)        q_r <= 1'b0;
            else if (set_i[i]) q_r <= 1'b1;
            else if (clr_i[i]) q_r <= 1'b0;
        end

        assign q_o[i] = q_r;

        assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
        assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);
        assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(q_o[i]));
        assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && set_i[i]) |=> q_o[i]);
    end
endmodule

// File: rtl/dma_stat_irq.sv
// Module: interrupt combiner for the DMA status word.
// Forms the done request from two flag/enable pairs, the error request from
// per-bit enabled error flags, and the abnormal-chain summary of the errors.
// Assumes: the enables are level signals from the configuration register.
module dma_stat_irq #(
    parameter int N_ERR = 5
) (
    input  logic             chain_f,
    input  logic             xfer_f,
    input  logic [N_ERR-1:0] err_f,
    input  logic             ie_chain,
    input  logic             ie_xfer,
    input  logic [N_ERR-1:0] ie_err,
    output logic             irq_done_o,
    output logic             irq_err_o,
    output logic             abn_o
);
    // Combine flags with enables into the two requests and the summary bit
    always_comb begin
        irq_done_o = (chain_f & ie_chain) | (xfer_f & ie_xfer);
        irq_err_o  = |(err_f & ie_err);
        abn_o      = |err_f;
    end
endmodule

// File: rtl/dma_stat_rdmux.sv
// Module: assembles the 32-bit status word from stored and live fields.
// Reserved positions are driven to 0.
// Assumes: the field layout of dma_stat_pkg.
module dma_stat_rdmux
    import dma_stat_pkg::*;
(
    input  logic [NUM_ERR-1:0] err_f,
    input  logic               xfer_f,
    input  logic               chain_f,
    input  logic               abn,
    input  logic               irq_done,
    input  logic               irq_err,
    input  live_t              live,
    output logic [WORD_W-1:0]  word_o
);
    // Place every field at its bit position, zero elsewhere
    always_comb begin
        word_o = '0;
        word_o[POS_ERR_LSB +: NUM_ERR] = err_f;
        word_o[POS_XFER]               = xfer_f;
        word_o[POS_CHAIN]              = chain_f;
        word_o[POS_ABN]                = abn;
        word_o[POS_XACT]               = live.xfer_act;
        word_o[POS_CHEN]               = live.chain_en;
        word_o[POS_IDONE]              = irq_done;
        word_o[POS_IERR]               = irq_err;
        word_o[POS_BUSY]               = live.busy;
        word_o[POS_RP_LSB +: PTR_W]    = live.rp;
        word_o[POS_WP_LSB +: PTR_W]    = live.wp;
        word_o[POS_CNT_LSB +: CNT_W]   = live.cnt;
    end
endmodule

// File: rtl/dma_stat_reg.sv
// Module: DMA status and interrupt register (top).
// Stores completion and error flags with write-one-to-clear, mirrors live
// FIFO, bus and configuration state, and drives two level interrupts.
// Assumes: event inputs are single-cycle pulses synchronous to clk.
module dma_stat_reg
    import dma_stat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   rd_data,
    input  logic                ev_chain_done,
    input  logic                ev_xfer_done,
    input  logic [NUM_ERR-1:0]  ev_err,
    input  logic [CNT_W-1:0]    fifo_cnt,
    input  logic [PTR_W-1:0]    fifo_wp,
    input  logic [PTR_W-1:0]    fifo_rp,
    input  logic                bus_busy,
    input  logic                cfg_chain_en,
    input  logic                cfg_xfer_act,
    input  logic                ie_chain_done,
    input  logic                ie_xfer_done,
    input  logic [NUM_ERR-1:0]  ie_err,
    output logic                irq_done,
    output logic                irq_err
);
    localparam int N_NORM = 2;

    logic [N_NORM-1:0]  norm_set, norm_clr, norm_q;
    logic [NUM_ERR-1:0] err_clr, err_q;
    logic               abn;
    live_t              live;

    // Route event pulses and qualified clear bits to the flag banks
    always_comb begin
        norm_set = {ev_chain_done, ev_xfer_done};
        norm_clr = {N_NORM{wr_en}} & {wr_data[POS_CHAIN], wr_data[POS_XFER]};
        err_clr  = {NUM_ERR{wr_en}} & wr_data[POS_ERR_LSB +: NUM_ERR];
    end

    // Bundle the live mirror inputs
    always_comb begin
        live.cnt      = fifo_cnt;
        live.wp       = fifo_wp;
        live.rp       = fifo_rp;
        live.busy     = bus_busy;
        live.chain_en = cfg_chain_en;
        live.xfer_act = cfg_xfer_act;
    end

    dma_stat_flag_bank #(.N(N_NORM)) i_norm_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (norm_set),
        .clr_i (norm_clr),
        .q_o   (norm_q)
    );

    dma_stat_flag_bank #(.N(NUM_ERR)) i_err_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_err),
        .clr_i (err_clr),
        .q_o   (err_q)
    );

    dma_stat_irq #(.N_ERR(NUM_ERR)) i_irq (
        .chain_f    (norm_q[1]),
        .xfer_f     (norm_q[0]),
        .err_f      (err_q),
        .ie_chain   (ie_chain_done),
        .ie_xfer    (ie_xfer_done),
        .ie_err     (ie_err),
        .irq_done_o (irq_done),
        .irq_err_o  (irq_err),
        .abn_o      (abn)
    );

    dma_stat_rdmux i_rdmux (
        .err_f    (err_q),
        .xfer_f   (norm_q[0]),
        .chain_f  (norm_q[1]),
        .abn      (abn),
        .irq_done (irq_done),
        .irq_err  (irq_err),
        .live     (live),
        .word_o   (rd_data)
    );

    assert_abn_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[POS_ABN] == (|rd_data[POS_ERR_LSB +: NUM_ERR]));
    assert_done_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ev_chain_done) && ie_chain_done) |-> irq_done);
    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_chain_done && !ie_xfer_done) |-> !irq_done);
    assert_err_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|($past(ev_err) & ie_err))) |-> irq_err);
    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_err == '0) |-> !irq_err);
    assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31:29] == 3'b000) && !rd_data[15] && (rd_data[6:5] == 2'b00));
endmodule

// File: tb/test_dma_stat_reg.sv
module test_dma_stat_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        ev_chain_done, ev_xfer_done;
    logic [4:0]  ev_err;
    logic [4:0]  fifo_cnt;
    logic [3:0]  fifo_wp, fifo_rp;
    logic        bus_busy, cfg_chain_en, cfg_xfer_act;
    logic        ie_chain_done, ie_xfer_done;
    logic [4:0]  ie_err;
    logic        irq_done, irq_err;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_stat_reg i_dma_stat_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ev_chain_done(ev_chain_done),
        .ev_xfer_done(ev_xfer_done), .ev_err(ev_err), .fifo_cnt(fifo_cnt),
        .fifo_wp(fifo_wp), .fifo_rp(fifo_rp), .bus_busy(bus_busy),
        .cfg_chain_en(cfg_chain_en), .cfg_xfer_act(cfg_xfer_act),
        .ie_chain_done(ie_chain_done), .ie_xfer_done(ie_xfer_done),
        .ie_err(ie_err), .irq_done(irq_done), .irq_err(irq_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of events and/or write, then settle at the next falling edge
    task automatic cycle(input logic ch, input logic xf, input logic [4:0] er,
                         input logic we, input logic [31:0] wd);
        @(negedge clk);
        ev_chain_done = ch; ev_xfer_done = xf; ev_err = er;
        wr_en = we; wr_data = wd;
        @(negedge clk);
        ev_chain_done = 0; ev_xfer_done = 0; ev_err = 0; wr_en = 0; wr_data = 0;
        #1;
    endtask

    task automatic clear_all();
        cycle(0, 0, 5'h00, 1, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check("R1 word", rd_data, 32'h0);
        check("R1 irqs", {30'h0, irq_done, irq_err}, 32'h0);
    endtask

    task automatic t_set();
        cycle(1, 0, 5'h00, 0, 0);
        check("R2 chain bit8", rd_data, 32'h0000_0100);
        cycle(0, 1, 5'h00, 0, 0);
        check("R2 xfer bit7", rd_data, 32'h0000_0180);
        cycle(0, 0, 5'b10101, 0, 0);
        check("R2 errors", rd_data, 32'h0000_0395);
        clear_all();
        check("R3 clear all", rd_data, 32'h0);
    endtask

    task automatic t_w1c();
        cycle(1, 1, 5'h1F, 0, 0);
        check("R2 all set", rd_data, 32'h0000_039F);
        cycle(0, 0, 5'h00, 1, 32'h0000_0004);
        check("R3 clear bit2", rd_data, 32'h0000_039B);
        cycle(0, 0, 5'h00, 1, 32'h0000_0000);
        check("R3 zeros ignored", rd_data, 32'h0000_039B);
        cycle(0, 0, 5'h00, 1, 32'h0000_0200);
        check("R5 bit9 write ignored", rd_data, 32'h0000_039B);
        cycle(0, 0, 5'h00, 1, 32'h0000_0013);
        check("R5 bit9 follows partial", rd_data, 32'h0000_0388);
        cycle(0, 0, 5'h00, 1, 32'h0000_0008);
        check("R5 bit9 drops", rd_data, 32'h0000_0180);
        cycle(0, 0, 5'h00, 1, 32'h0000_0100);
        check("R3 clear bit8", rd_data, 32'h0000_0080);
        clear_all();
    endtask

    task automatic t_set_wins();
        cycle(0, 0, 5'b00010, 1, 32'h0000_0002);
        check("R4 error collide", rd_data, 32'h0000_0202);
        cycle(1, 0, 5'h00, 1, 32'h0000_0102);
        check("R4 chain collide", rd_data, 32'h0000_0100);
        clear_all();
    endtask

    task automatic t_done_irq();
        ie_chain_done = 0; ie_xfer_done = 0;
        cycle(1, 0, 5'h00, 0, 0);
        check("R6 disabled", {31'h0, irq_done}, 32'h0);
        ie_chain_done = 1; #1;
        check("R6 chain pair", {31'h0, irq_done}, 32'h1);
        check("R6 bit12", rd_data, 32'h0000_1100);
        cycle(0, 1, 5'h00, 1, 32'h0000_0100);
        check("R6 chain cleared", {31'h0, irq_done}, 32'h0);
        ie_xfer_done = 1; #1;
        check("R6 xfer pair", {19'h0, rd_data[12], 11'h0, irq_done}, {19'h0, 1'b1, 11'h0, 1'b1});
        ie_xfer_done = 0; #1;
        check("R6 xfer disabled", {31'h0, irq_done}, 32'h0);
        ie_chain_done = 0;
        clear_all();
    endtask

    task automatic t_err_irq();
        ie_err = 5'b00100;
        cycle(0, 0, 5'b01000, 0, 0);
        check("R7 wrong enable", {31'h0, irq_err}, 32'h0);
        ie_err = 5'b01000; #1;
        check("R7 matching enable", {31'h0, irq_err}, 32'h1);
        check("R7 bit13", rd_data, 32'h0000_2208);
        cycle(0, 0, 5'h00, 1, 32'h0000_0008);
        check("R7 cleared", {31'h0, irq_err}, 32'h0);
        ie_err = 0;
    endtask

    task automatic t_mirrors();
        fifo_cnt = 5'h15; fifo_wp = 4'hA; fifo_rp = 4'h3;
        bus_busy = 1; cfg_chain_en = 1; cfg_xfer_act = 0; #1;
        check("R10 R9 R8 pattern A", rd_data, 32'h15A3_4800);
        fifo_cnt = 5'h0A; fifo_wp = 4'h5; fifo_rp = 4'hC;
        bus_busy = 0; cfg_chain_en = 0; cfg_xfer_act = 1; #1;
        check("R10 R9 R8 pattern B", rd_data, 32'h0A5C_0400);
        fifo_cnt = 0; fifo_wp = 0; fifo_rp = 0; cfg_xfer_act = 0; #1;
        check("R10 zero", rd_data, 32'h0);
    endtask

    task automatic t_reserved();
        cycle(1, 1, 5'h1F, 0, 0);
        cycle(0, 0, 5'h00, 1, 32'hE000_8060);
        check("R11 reserved writes", rd_data, 32'h0000_039F);
        clear_all();
    endtask

    task automatic t_reset_clears();
        cycle(1, 1, 5'h1F, 0, 0);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; #1;
        check("R1 reset clears flags", rd_data, 32'h0);
    endtask

    initial begin
        rst_n = 0; wr_en = 0; wr_data = 0;
        ev_chain_done = 0; ev_xfer_done = 0; ev_err = 0;
        fifo_cnt = 0; fifo_wp = 0; fifo_rp = 0;
        bus_busy = 0; cfg_chain_en = 0; cfg_xfer_act = 0;
        ie_chain_done = 0; ie_xfer_done = 0; ie_err = 0;
        t_reset();
        t_set();
        t_w1c();
        t_set_wins();
        t_done_irq();
        t_err_irq();
        t_mirrors();
        t_reserved();
        t_reset_clears();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule